// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block derives the two timing strobes a serial transmitter and receiver need from the system clock. A down-counter runs at the system clock and is reloaded from a 12-bit divisor whenever it reaches zero. Each zero produces one base tick, so the base tick rate is fclk/(divisor+1). The receiver uses the base tick directly as its oversampling strobe. A prescaler counts base ticks to form the transmit bit tick. It divides by 16 in normal asynchronous mode, by 8 in double-speed asynchronous mode and by 2 in synchronous master mode.

The divisor is loaded through two byte-lane strobes. A low-lane write reloads the counter at once and cuts short the count in progress. A high-lane write alone only changes the value used at the next reload. The block has no data stream, so every pin is a plain control or status pin with no valid/ready handshake. Both outputs are one-cycle pulses in the system clock domain.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, the divisor, the counter and the prescaler clear to zero and the mode resets to normal. So with normal mode inputs, `base_tick` is high in every cycle from the first cycle after reset, and the first `tx_tick` comes on the 16th base tick.
- R2: With divisor D and no writes, `base_tick` pulses exactly once every D+1 clock cycles. Each pulse is one cycle wide when D is nonzero.
- R3: A low-lane write (`lo_we` high on a rising edge) loads the counter with the new divisor N on that edge. `base_tick` is then low and next goes high exactly N rising edges later (N>0). After that, the period is N+1.
- R4: A high-lane write without a low-lane write does not disturb the count in progress. The new high bits take effect from the next natural reload.
- R5: `tx_tick` has a period of 16 base ticks when `sync_mode`=0 and `dbl_speed`=0, 8 base ticks when `sync_mode`=0 and `dbl_speed`=1, and 2 base ticks when `sync_mode`=1.
- R6: When `sync_mode`=1, changing `dbl_speed` has no effect on either tick output, including the phase of `tx_tick`.
- R7: When the selected transmit ratio changes, the prescaler restarts from zero. The first `tx_tick` in the new mode falls on the L-th base tick after the edge that saw the change, where L is the new ratio. Base ticks in the cycle of the change are not counted.
- R8: `tx_tick` is high only in cycles where `base_tick` is high. After a `tx_tick`, the prescaler starts a new period from zero.
- R9: The divisor is `{hi_data[3:0], lo_data[7:0]}`. When both lanes are written on the same edge, the reload uses both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_data | input | 8 | Low divisor lane value |
| lo_we | input | 1 | Low-lane write strobe; also reloads the counter |
| hi_data | input | 4 | High divisor lane value |
| hi_we | input | 1 | High-lane write strobe |
| sync_mode | input | 1 | 1 selects synchronous master (ratio 2) |
| dbl_speed | input | 1 | 1 selects double speed (ratio 8) in asynchronous mode |
| base_tick | output | 1 | Receiver oversampling strobe, one pulse per counter underflow |
| tx_tick | output | 1 | Transmit bit strobe |

## Verification
A wrong counter value shows as a `base_tick` interval that differs from D+1 within a single period. For a reload fault, the interval after a low-lane write shows it within N cycles. A prescaler that is off by one, or that is not cleared on a mode change, moves the next `tx_tick` away from the expected base tick. This is visible within one transmit period, at most 16 base ticks. A mode decoded wrongly changes the `tx_tick` spacing by a factor of 2 or more from the next period on, so the spacing of the two pulse trains is measured across mode switches and lane writes.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_DOUBLE = 2'd1,
    TM_SYNC   = 2'd2
  } tx_mode_e;

  // synchronous master wins; double speed only matters when asynchronous
  function automatic tx_mode_e decode_mode(input logic sync_sel, input logic dbl_sel);
    if (sync_sel)     return TM_SYNC;
    else if (dbl_sel) return TM_DOUBLE;
    else              return TM_NORMAL;
  endfunction

endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8,
  localparam int HI_W  = DIV_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] lo_data,
  input  logic              lo_we,
  input  logic [HI_W-1:0]   hi_data,
  input  logic              hi_we,
  output logic [DIV_W-1:0]  div_q,
  output logic              reload_now,
  output logic [DIV_W-1:0]  reload_val
);

  logic [HI_W-1:0]   hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_next;

  assign hi_next = hi_we ? hi_data : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= hi_data;
      if (lo_we) lo_q <= lo_data;
    end
  end

  assign div_q      = {hi_q, lo_q};
  assign reload_now = lo_we;
  assign reload_val = {hi_next, lo_data};

  p_hi_lane_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> hi_q == $past(hi_q));
  p_lo_lane_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> lo_q == $past(lo_data));

endmodule

// File: rtl/baud_downcnt.sv
module baud_downcnt #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic             reload_now,
  input  logic [DIV_W-1:0] reload_val,
  output logic             base_tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (reload_now)        cnt_q <= reload_val;
    else if (cnt_q == '0)       cnt_q <= div_q;
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign base_tick = (cnt_q == '0);

  p_lo_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_now |=> cnt_q == $past(reload_val));
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_now && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_underflow_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_now && cnt_q == '0) |=> cnt_q == $past(div_q));
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && !reload_now && div_q != '0) |=> !base_tick);

endmodule

// File: rtl/tx_prescaler.sv
module tx_prescaler
  import baud_pkg::*;
#(
  parameter int NORM_RATIO = 16,
  parameter int DBL_RATIO  = 8,
  parameter int SYNC_RATIO = 2,
  localparam int PRE_W     = $clog2(NORM_RATIO)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic sync_mode,
  input  logic dbl_speed,
  output logic tx_tick
);

  tx_mode_e         mode_now;
  tx_mode_e         mode_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_q;
  logic             mode_chg;

  assign mode_now = decode_mode(sync_mode, dbl_speed);
  assign mode_chg = (mode_now != mode_q);

  always_comb begin
    unique case (mode_q)
      TM_DOUBLE: last_q = PRE_W'(DBL_RATIO - 1);
      TM_SYNC:   last_q = PRE_W'(SYNC_RATIO - 1);
      default:   last_q = PRE_W'(NORM_RATIO - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= TM_NORMAL;
      pre_q  <= '0;
    end else if (mode_chg) begin
      mode_q <= mode_now;
      pre_q  <= '0;
    end else if (base_tick) begin
      pre_q <= (pre_q == last_q) ? '0 : pre_q + 1'b1;
    end
  end

  assign tx_tick = base_tick && (pre_q == last_q);

  p_pre_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= last_q);
  p_mode_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> pre_q == '0);
  p_wrap_after_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && !mode_chg) |=> pre_q == '0);
  p_dbl_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(sync_mode) && mode_q == TM_SYNC) |-> !mode_chg);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W      = 12,
  parameter int BYTE_W     = 8,
  parameter int NORM_RATIO = 16,
  parameter int DBL_RATIO  = 8,
  parameter int SYNC_RATIO = 2,
  localparam int HI_W      = DIV_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] lo_data,
  input  logic              lo_we,
  input  logic [HI_W-1:0]   hi_data,
  input  logic              hi_we,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  output logic              base_tick,
  output logic              tx_tick
);

  logic [DIV_W-1:0] div_q;
  logic             reload_now;
  logic [DIV_W-1:0] reload_val;

  baud_div_reg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_data    (lo_data),
    .lo_we      (lo_we),
    .hi_data    (hi_data),
    .hi_we      (hi_we),
    .div_q      (div_q),
    .reload_now (reload_now),
    .reload_val (reload_val)
  );

  baud_downcnt #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_q      (div_q),
    .reload_now (reload_now),
    .reload_val (reload_val),
    .base_tick  (base_tick)
  );

  tx_prescaler #(
    .NORM_RATIO (NORM_RATIO),
    .DBL_RATIO  (DBL_RATIO),
    .SYNC_RATIO (SYNC_RATIO)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .sync_mode (sync_mode),
    .dbl_speed (dbl_speed),
    .tx_tick   (tx_tick)
  );

  p_tx_inside_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> base_tick);

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lo_data = '0;
  logic       lo_we = 1'b0;
  logic [3:0] hi_data = '0;
  logic       hi_we = 1'b0;
  logic       sync_mode = 1'b0;
  logic       dbl_speed = 1'b0;
  logic       base_tick;
  logic       tx_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  baud_tick_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_data   (lo_data),
    .lo_we     (lo_we),
    .hi_data   (hi_data),
    .hi_we     (hi_we),
    .sync_mode (sync_mode),
    .dbl_speed (dbl_speed),
    .base_tick (base_tick),
    .tx_tick   (tx_tick)
  );

  // {sync, dbl, divisor[11:0], base period, tx period}
  localparam int NV = 7;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd0,     16'd1,   16'd16},
    {1'b0, 1'b1, 12'd3,     16'd4,   16'd32},
    {1'b1, 1'b0, 12'd5,     16'd6,   16'd12},
    {1'b1, 1'b1, 12'd2,     16'd3,   16'd6},
    {1'b0, 1'b0, 12'h102,   16'd259, 16'd4144},
    {1'b0, 1'b1, 12'd9,     16'd10,  16'd80},
    {1'b1, 1'b0, 12'd0,     16'd1,   16'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit do_lo, input bit do_hi, input logic [7:0] lo, input logic [3:0] hi);
    @(negedge clk);
    lo_data = lo; hi_data = hi; lo_we = do_lo; hi_we = do_hi;
    @(negedge clk);
    lo_we = 1'b0; hi_we = 1'b0;
  endtask

  // negedges until the selected pulse is seen
  task automatic gap(input bit on_tx, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(on_tx ? tx_tick : base_tick) && n < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: divisor zero, tick every cycle, prescaler starts at zero
    chk(base_tick == 1'b1, "R1 base_tick after reset", base_tick, 1);
    chk(tx_tick == 1'b0, "R1 tx_tick after reset", tx_tick, 0);
    gap(1'b1, g);
    chk(g == 15, "R1 first tx_tick position", g, 15);

    // table: R2 base period, R5 tx ratio, R6 dbl ignored in sync
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sync_mode = VEC[i][45];
      dbl_speed = VEC[i][44];
      wr(1'b0, 1'b1, 8'h00, VEC[i][43:40]);
      wr(1'b1, 1'b0, VEC[i][39:32], 4'h0);
      gap(1'b1, g);
      gap(1'b1, g);
      chk(g == int'(VEC[i][15:0]), $sformatf("R5 tx period vec %0d", i), g, int'(VEC[i][15:0]));
      gap(1'b0, g);
      chk(g == int'(VEC[i][31:16]), $sformatf("R2 base period vec %0d", i), g, int'(VEC[i][31:16]));
    end

    // R3: low-lane write cuts the count short
    @(negedge clk); sync_mode = 1'b0; dbl_speed = 1'b0;
    wr(1'b0, 1'b1, 8'h00, 4'h0);
    wr(1'b1, 1'b0, 8'd200, 4'h0);
    repeat (37) @(negedge clk);
    wr(1'b1, 1'b0, 8'd5, 4'h0);
    chk(base_tick == 1'b0, "R3 no tick right after reload", base_tick, 0);
    gap(1'b0, g);
    chk(g == 5, "R3 first tick after low write", g, 5);
    gap(1'b0, g);
    chk(g == 6, "R3 period after low write", g, 6);

    // R4: high-lane write alone keeps the running count
    wr(1'b1, 1'b0, 8'd3, 4'h0);
    gap(1'b0, g);
    gap(1'b0, g);
    wr(1'b0, 1'b1, 8'h00, 4'h1);
    gap(1'b0, g);
    chk(g == 2, "R4 current count undisturbed", g, 2);
    gap(1'b0, g);
    chk(g == 260, "R4 new divisor from next reload", g, 260);

    // R9: both lanes on the same edge
    wr(1'b1, 1'b1, 8'h02, 4'h1);
    gap(1'b0, g);
    chk(g == 258, "R9 combined reload first tick", g, 258);
    gap(1'b0, g);
    chk(g == 259, "R9 combined divisor period", g, 259);

    // R6: toggling dbl_speed in sync mode keeps tx phase
    @(negedge clk); sync_mode = 1'b1; dbl_speed = 1'b0;
    wr(1'b1, 1'b1, 8'd3, 4'h0);
    gap(1'b1, g);
    gap(1'b1, g);
    chk(g == 8, "R6 sync tx period", g, 8);
    repeat (3) @(negedge clk);
    dbl_speed = 1'b1;
    g = 3;
    do begin @(negedge clk); g++; end while (!tx_tick && g < 100);
    chk(g == 8, "R6 tx phase after dbl toggle", g, 8);

    // R7: mode change restarts the prescaler
    @(negedge clk); sync_mode = 1'b0; dbl_speed = 1'b0;
    wr(1'b1, 1'b1, 8'd0, 4'h0);
    gap(1'b1, g);
    gap(1'b1, g);
    chk(g == 16, "R7 normal period before switch", g, 16);
    repeat (5) @(negedge clk);
    dbl_speed = 1'b1;
    gap(1'b1, g);
    chk(g == 8, "R7 first tx after switch", g, 8);

    // R8: tx only with base, sampled over a run
    @(negedge clk); sync_mode = 1'b0; dbl_speed = 1'b1;
    wr(1'b1, 1'b0, 8'd2, 4'h0);
    begin
      int bad = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (tx_tick && !base_tick) bad++;
      end
      chk(bad == 0, "R8 tx outside base tick", bad, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule